// File: doc/BRIEF.md
# Line-Derived 8 kHz Frame Reference with Holdover

This block turns the frame-start indications of one chosen receive line into an 8 kHz reference square wave for line timing of a transmitter or ring node. Several receive lines feed it. Each line brings a single-cycle frame-start strobe plus loss-of-clock and loss-of-frame flags, all already synchronous to the local clock. A select input picks the line that steers the reference. One half-period counter, clocked by the local reference clock, sets the output's timing. When the selected line is in frame (neither loss flag set), every frame-start strobe re-phases that counter so that a rising edge of the output coincides with the received frame start. The output then has a 50% duty cycle and a period of one frame (125 us).

When the selected line reports loss of clock or loss of frame, the strobes are no longer trusted. The counter simply keeps dividing the local clock, so the output stays present but runs free. A validity output drops in that case. A provisioning enable gates both outputs. While it is low, the reference output is held low and marked invalid, but the divider keeps running underneath.

Re-locking never produces a high or low pulse shorter than a half period. A strobe that lands in a high phase stretches that high phase. A strobe that lands early in a low phase stretches the low phase. Within two frames the output settles onto the strobe timing.

Top module: `frmref_gen`

## Requirements
- R1: While `rst` is high, `ref_out` and `ref_valid` are 0. After reset the internal phase is low with the half-period count at zero.
- R2: With the selected line out of frame and `prov_en` high, `ref_out` stays low for the first HALF clocks after reset is released. After that it toggles every HALF clocks.
- R3: While the selected line has `line_loc` or `line_lof` set, its frame-start strobes have no effect on `ref_out`.
- R4: While the selected line is in frame and strobes arrive every 2*HALF clocks, `ref_out` rises at the clock edge that samples each strobe, stays high for HALF clocks and low for HALF clocks.
- R5: An in-frame strobe sampled while the phase is high keeps the output high and restarts the high half period from that edge.
- R6: An in-frame strobe sampled while the phase is low, before the low half period has completed, keeps the output low for HALF more clocks from that edge.
- R7: The internal phase never holds a level for fewer than HALF clocks.
- R8: `ref_valid` is registered: after each clock edge it equals `prov_en` AND the selected line having neither `line_loc` nor `line_lof` set, as sampled at that edge.
- R9: While `prov_en` is low, `ref_out` and `ref_valid` are 0, and the divider keeps running. Once `prov_en` is high again, `ref_out` follows the phase that was kept running in the meantime.
- R10: `line_sel` picks bit `line_sel` of `line_fs`, `line_loc` and `line_lof`. The strobes and loss flags of the other lines have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local reference clock; the divider counts it |
| rst | input | 1 | Synchronous active-high reset |
| prov_en | input | 1 | Provisioning enable; gates both outputs |
| line_sel | input | SELW | Index of the receive line that steers the reference |
| line_fs | input | NLINES | Per-line frame-start strobe, one clock wide |
| line_loc | input | NLINES | Per-line loss-of-clock flag |
| line_lof | input | NLINES | Per-line loss-of-frame flag |
| ref_out | output | 1 | 8 kHz frame reference, gated by `prov_en` |
| ref_valid | output | 1 | High when the reference is provisioned and locked to an in-frame line |

## Verification
The hardest situations to reach are the two re-phasing cases: a strobe landing part-way through a high phase, and a strobe landing part-way through a low phase. In steady lock, strobes only ever coincide with the end of a low phase. The stimulus starts from reset with the divider free-running, so every phase boundary sits at a known clock count. It then brings the line into frame and places single strobes two clocks into a high phase and two clocks into a low phase. Next it applies a strobe train at the frame rate and checks that the output converges onto it. The phase, still known, is then used to check holdover, strobes from lines that are not selected, and re-enabling after a period without provisioning.

// File: rtl/frmref_pkg.sv
package frmref_pkg;

    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_LOCK = 1'b1
    } ref_mode_e;

    typedef struct packed {
        logic strobe;
        logic in_frame;
    } line_view_t;

    function automatic logic half_done(input int unsigned cnt, input int unsigned half);
        return cnt == (half - 1);
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/frmref_line_sel.sv
module frmref_line_sel
    import frmref_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int SELW   = 2
) (
    input  logic [SELW-1:0]   sel,
    input  logic [NLINES-1:0] fs,
    input  logic [NLINES-1:0] loc,
    input  logic [NLINES-1:0] lof,
    output line_view_t        view
);

    logic [NLINES-1:0] ok;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign ok[i] = ~(loc[i] | lof[i]);
    end

    always_comb begin
        view = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (sel == SELW'(i)) begin
                view.strobe   = fs[i];
                view.in_frame = ok[i];
            end
        end
    end

endmodule

// File: rtl/frmref_phase.sv
module frmref_phase
    import frmref_pkg::*;
#(
    parameter int HALF = 3888
) (
    input  logic       clk,
    input  logic       rst,
    input  line_view_t view,
    output logic       ph_q,
    output logic       ph_d,
    output ref_mode_e  mode
);

    localparam int CW = width_of(HALF);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          done;

    assign mode = view.in_frame ? MODE_LOCK : MODE_HOLD;

    always_comb begin
        done  = half_done(32'(cnt_q), HALF);
        cnt_d = cnt_q + CW'(1);
        ph_d  = ph_q;
        if (mode == MODE_LOCK && view.strobe) begin
            cnt_d = '0;
            ph_d  = ph_q | done;
        end else if (done) begin
            cnt_d = '0;
            ph_d  = ~ph_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ph_q  <= ph_d;
        end
    end

endmodule

// File: rtl/frmref_out.sv
module frmref_out
    import frmref_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      prov_en,
    input  logic      ph_d,
    input  ref_mode_e mode,
    output logic      ref_out,
    output logic      ref_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_out   <= 1'b0;
            ref_valid <= 1'b0;
        end else begin
            ref_out   <= ph_d & prov_en;
            ref_valid <= prov_en & (mode == MODE_LOCK);
        end
    end

endmodule

// File: rtl/frmref_gen.sv
module frmref_gen
    import frmref_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int HALF   = 3888,
    parameter int SELW   = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prov_en,
    input  logic [SELW-1:0]   line_sel,
    input  logic [NLINES-1:0] line_fs,
    input  logic [NLINES-1:0] line_loc,
    input  logic [NLINES-1:0] line_lof,
    output logic              ref_out,
    output logic              ref_valid
);

    line_view_t view;
    logic       ph_q;
    logic       ph_d;
    ref_mode_e  mode;

    frmref_line_sel #(.NLINES(NLINES), .SELW(SELW)) u_sel (
        .sel  (line_sel),
        .fs   (line_fs),
        .loc  (line_loc),
        .lof  (line_lof),
        .view (view)
    );

    frmref_phase #(.HALF(HALF)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .view (view),
        .ph_q (ph_q),
        .ph_d (ph_d),
        .mode (mode)
    );

    frmref_out u_out (
        .clk       (clk),
        .rst       (rst),
        .prov_en   (prov_en),
        .ph_d      (ph_d),
        .mode      (mode),
        .ref_out   (ref_out),
        .ref_valid (ref_valid)
    );

endmodule

// File: rtl/frmref_chk.sv
module frmref_chk #(
    parameter int NLINES = 4,
    parameter int HALF   = 3888,
    parameter int SELW   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              prov_en,
    input logic [SELW-1:0]   line_sel,
    input logic [NLINES-1:0] line_fs,
    input logic [NLINES-1:0] line_loc,
    input logic [NLINES-1:0] line_lof,
    input logic              ph,
    input logic              ref_out,
    input logic              ref_valid
);

    localparam int RW = ((HALF > 1) ? $clog2(HALF) : 1) + 1;

    logic          sel_in_range;
    logic          sel_ok;
    logic          sel_fs;
    logic          ph_prev;
    logic [RW-1:0] run;

    assign sel_in_range = (32'(line_sel) < NLINES);
    assign sel_ok = sel_in_range && !line_loc[line_sel] && !line_lof[line_sel];
    assign sel_fs = sel_in_range && line_fs[line_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_prev <= 1'b0;
            run     <= '0;
        end else begin
            ph_prev <= ph;
            if (ph != ph_prev) begin
                run <= '0;
            end else if (run != {RW{1'b1}}) begin
                run <= run + RW'(1);
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ref_out && !ref_valid));

    p_min_run_r7: assert property (@(posedge clk) disable iff (rst)
        (ph != ph_prev) |-> (32'(run) >= HALF - 1));

    p_valid_track_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ref_valid == $past(prov_en && sel_ok)));

    p_gate_off_r9: assert property (@(posedge clk) disable iff (rst)
        !prov_en |=> (!ref_out && !ref_valid));

    p_strobe_keeps_high_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_ok && sel_fs && ph) |=> ph);

endmodule

bind frmref_gen frmref_chk #(.NLINES(NLINES), .HALF(HALF), .SELW(SELW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .prov_en   (prov_en),
    .line_sel  (line_sel),
    .line_fs   (line_fs),
    .line_loc  (line_loc),
    .line_lof  (line_lof),
    .ph        (ph_q),
    .ref_out   (ref_out),
    .ref_valid (ref_valid)
);

// File: tb/frmref_gen_bench.sv
module frmref_gen_bench;

    localparam int NL = 4;
    localparam int H  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prov_en = 1'b0;
    logic [1:0]    sel = 2'd0;
    logic [NL-1:0] fs  = '0;
    logic [NL-1:0] loc = '1;
    logic [NL-1:0] lof = '0;
    logic          ref_out;
    logic          ref_valid;

    always #5 clk = ~clk;

    frmref_gen #(.NLINES(NL), .HALF(H)) u_frmref_gen (
        .clk       (clk),
        .rst       (rst),
        .prov_en   (prov_en),
        .line_sel  (sel),
        .line_fs   (fs),
        .line_loc  (loc),
        .line_lof  (lof),
        .ref_out   (ref_out),
        .ref_valid (ref_valid)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    is_valid;
        logic  val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    task automatic expect_at(int at, bit is_valid, logic val, string tag);
        exp_t e;
        int   i;
        e.at = at; e.is_valid = is_valid; e.val = val; e.tag = tag;
        i = 0;
        while (i < q.size() && q[i].at <= at) i++;
        q.insert(i, e);
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            logic act;
            e = q.pop_front();
            act = e.is_valid ? ref_valid : ref_out;
            checks++;
            if (e.at < cyc || act !== e.val) begin
                fails++;
                $display("FAIL %s cycle %0d %s actual=%b expected=%b",
                         e.tag, e.at, e.is_valid ? "ref_valid" : "ref_out", act, e.val);
            end
        end
    end

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_fs(int line, int edge_n);
        wait_until(edge_n - 1);
        fs[line] = 1'b1;
        @(negedge clk);
        fs[line] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        int n0, e, f, g;
        @(negedge clk);
        prov_en = 1'b1;
        expect_at(cyc + 1, 0, 1'b0, "R1");
        expect_at(cyc + 2, 1, 1'b0, "R1");
        wait_until(cyc + 3);
        rst = 1'b0;
        n0 = cyc;

        // R2 free run from reset; R3 strobe ignored while line 0 has loss of clock
        expect_at(n0 + H - 1, 0, 1'b0, "R2");
        expect_at(n0 + H,     0, 1'b1, "R2");
        expect_at(n0 + H,     1, 1'b0, "R8");
        expect_at(n0 + 2*H - 1, 0, 1'b1, "R2");
        expect_at(n0 + 2*H,   0, 1'b0, "R3");
        expect_at(n0 + 3*H,   0, 1'b1, "R2");
        pulse_fs(0, n0 + H + 2);

        // lines 0 and 1 come into frame; lines 2 and 3 stay lost
        wait_until(n0 + 4*H);
        loc = 4'b1100;
        expect_at(n0 + 4*H + 1, 1, 1'b1, "R8");

        e = n0 + 5*H + 2;
        f = e + H + 2;
        g = f + 4*H;
        expect_at(e + H - 2, 0, 1'b1, "R5");
        expect_at(e + H - 1, 0, 1'b1, "R5");
        expect_at(e + H,     0, 1'b0, "R5");
        expect_at(e + 2*H,   0, 1'b0, "R6");
        expect_at(f + H - 1, 0, 1'b0, "R6");
        expect_at(f + H,     0, 1'b1, "R6");
        expect_at(g - 1,       0, 1'b0, "R4");
        expect_at(g,           0, 1'b1, "R4");
        expect_at(g + H - 1,   0, 1'b1, "R4");
        expect_at(g + H,       0, 1'b0, "R4");
        expect_at(g + 2*H - 1, 0, 1'b0, "R4");
        expect_at(g + 2*H,     0, 1'b1, "R4");
        // R10 strobe on unselected line 1 is ignored; lost lines 2,3 do not clear validity
        expect_at(g + 3*H - 1, 0, 1'b1, "R10");
        expect_at(g + 3*H,     0, 1'b0, "R10");
        expect_at(g + 3*H,     1, 1'b1, "R10");
        pulse_fs(0, e);
        pulse_fs(0, f);
        pulse_fs(0, f + 2*H);
        pulse_fs(0, f + 4*H);
        pulse_fs(0, f + 6*H);
        pulse_fs(1, g + 2*H + 2);

        // R10 selecting a lost line clears validity; R8 loss of frame on line 0
        wait_until(g + 3*H + 1);
        sel = 2'd2;
        expect_at(g + 3*H + 2, 1, 1'b0, "R10");
        wait_until(g + 3*H + 3);
        sel = 2'd0;
        expect_at(g + 3*H + 4, 1, 1'b1, "R10");
        wait_until(g + 3*H + 5);
        lof[0] = 1'b1;
        expect_at(g + 3*H + 6, 1, 1'b0, "R8");

        // R3 strobe during holdover high phase does not stretch it
        expect_at(g + 5*H - 1, 0, 1'b1, "R3");
        expect_at(g + 5*H,     0, 1'b0, "R3");
        pulse_fs(0, g + 4*H + 2);

        // R9 provisioning off gates outputs, divider keeps running
        expect_at(g + 6*H + 2, 0, 1'b0, "R9");
        expect_at(g + 6*H + 4, 0, 1'b0, "R9");
        expect_at(g + 6*H + 4, 1, 1'b0, "R9");
        expect_at(g + 8*H + 2, 0, 1'b1, "R9");
        expect_at(g + 9*H,     0, 1'b0, "R9");
        expect_at(g + 10*H,    0, 1'b1, "R9");
        wait_until(g + 6*H + 1);
        prov_en = 1'b0;
        wait_until(g + 8*H + 1);
        prov_en = 1'b1;

        wait_until(g + 11*H);
        @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard left %0d expected items, expected 0", q.size());
        end
        finish_run();
    end

endmodule